// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

This block is one channel of a programmable counter array. A free-running 16-bit timebase counter outside the block feeds its current value into the channel. An 8-bit mode word selects what the channel does with that value. In the capture modes, the channel latches the counter when an external input changes level. In the compare modes, it raises a flag or toggles its output pin when the counter reaches a programmed value. In the PWM modes it generates a pulse-width-modulated waveform. In frequency mode it produces a square wave whose half-period is set by a programmable step.

The external input first passes through a two-flop synchronizer. A two-sample stability filter follows, so that a level must be held for two clocks before an edge on it counts. The channel's 16-bit capture/compare register can be written by software at any time. A sticky flag records every capture or match and is cleared only by an explicit strobe. The interrupt request is the flag gated by an enable bit in the mode word.

The mode decoder is a small state machine. Its states are CH_IDLE, CH_CAP_RISE, CH_CAP_FALL, CH_CAP_ANY, CH_TIMER, CH_TOGGLE, CH_FREQ, CH_PWM_NARROW and CH_PWM_WIDE. There is one transition, MODE_WRITE: on any clock with `mode_we` high, the machine moves from any state to the state decoded from `mode_wdata`, and otherwise it stays where it is. Reset enters CH_IDLE.

Top module: `ccu_channel`

## Requirements
- R1: After reset, `ccreg`, `flag`, `irq` and `pin_out` are 0 and the channel is in CH_IDLE.
- R2: The mode word has these fields: bit0 capture-on-rise, bit1 capture-on-fall, bit2 compare enable, bit3 match enable, bit4 toggle enable, bit5 PWM enable, bit6 wide PWM, bit7 interrupt enable. The words decode as follows, and any other word selects CH_IDLE:
  - Capture modes: bit0 and/or bit1 set with bits 2..5 clear (bits 6 and 7 are ignored). Rise only is CH_CAP_RISE, fall only is CH_CAP_FALL, and both is CH_CAP_ANY.
  - Timer and toggle modes: bits 2 and 3 set with bits 0, 1 and 5 clear. This is CH_TIMER when bit4 is 0 and CH_TOGGLE when bit4 is 1.
  - Frequency and PWM modes: bits 2 and 5 set with bits 0, 1 and 3 clear. This is CH_FREQ when bit4 is 1, and otherwise CH_PWM_NARROW (bit6=0) or CH_PWM_WIDE (bit6=1).
  - In CH_IDLE, the counter causes no flag, no capture and no pin change.
- R3: In a capture mode, an accepted edge of the selected polarity loads the full 16-bit counter value into `ccreg` and sets `flag`. This happens on the fourth rising clock edge after the input changes.
- R4: An input pulse lasting a single clock produces no capture. An edge of the polarity not selected produces no capture and no flag.
- R5: In CH_TIMER and CH_TOGGLE, `flag` is set at the clock edge where `count_in` equals `ccreg`. In CH_TOGGLE, `pin_out` also inverts at that edge. In CH_TIMER, `pin_out` is unchanged.
- R6: In CH_PWM_NARROW, `pin_out` is 0 after each edge if `count_in[7:0] < ccreg[7:0]`, and 1 otherwise.
- R7: In CH_PWM_WIDE, `pin_out` is 0 after each edge if `count_in < ccreg`, and 1 otherwise (16-bit compare).
- R8: In CH_FREQ, at each edge where `count_in[7:0]` equals `ccreg[7:0]`, `pin_out` inverts and `ccreg[7:0]` becomes `ccreg[7:0] + ccreg[15:8]` modulo 256.
- R9: `flag` stays set until `flag_clr` is pulsed. If a hardware set and `flag_clr` occur in the same cycle, the set wins.
- R10: `irq` is high exactly when `flag` is 1 and mode-word bit7 is set.
- R11: A write on `reg_we` takes priority over a capture or frequency reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_in | input | 16 | Shared timebase counter value |
| pin_in | input | 1 | External input, asynchronous |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 8 | Mode word write data |
| reg_we | input | 1 | Capture/compare register write strobe |
| reg_wdata | input | 16 | Capture/compare register write data |
| flag_clr | input | 1 | Flag clear strobe |
| pin_out | output | 1 | Channel output pin |
| ccreg | output | 16 | Capture/compare register |
| flag | output | 1 | Sticky capture/match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each paired here with the fault it would expose:

- **Single-clock glitch:** a missing filter would capture it.
- **Edge of the unselected polarity:** a wrong polarity decode would latch it and raise the flag.
- **Capture latency:** the bench checks the exact edge of the capture, so an extra or missing pipeline stage shifts the observed edge.
- **Set versus clear in the same cycle:** if the clear won, the flag would read 0.
- **PWM byte compare:** the bench uses a counter whose high byte is large while its low byte is small. An 8-bit PWM that compared all 16 bits would drive the pin high there.
- **Frequency reload across the byte boundary:** a design that did not wrap modulo 256 would carry into the high byte.
- **Register write versus reload:** a design that let the reload override the write would show the reloaded value instead of the written one.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    localparam int MODE_W = 8;

    // mode word field positions
    localparam int MB_RISE  = 0;
    localparam int MB_FALL  = 1;
    localparam int MB_CMP   = 2;
    localparam int MB_MATCH = 3;
    localparam int MB_TOG   = 4;
    localparam int MB_PWM   = 5;
    localparam int MB_WIDE  = 6;
    localparam int MB_IRQEN = 7;

    typedef enum logic [3:0] {
        CH_IDLE,
        CH_CAP_RISE,
        CH_CAP_FALL,
        CH_CAP_ANY,
        CH_TIMER,
        CH_TOGGLE,
        CH_FREQ,
        CH_PWM_NARROW,
        CH_PWM_WIDE
    } chmode_t;

    function automatic chmode_t decode_mode(input logic [MODE_W-1:0] w);
        chmode_t m;
        logic    any_cap;
        any_cap = w[MB_RISE] | w[MB_FALL];
        m = CH_IDLE;
        if (any_cap && !w[MB_CMP] && !w[MB_MATCH] && !w[MB_TOG] && !w[MB_PWM]) begin
            if (w[MB_RISE] && w[MB_FALL])
                m = CH_CAP_ANY;
            else if (w[MB_RISE])
                m = CH_CAP_RISE;
            else
                m = CH_CAP_FALL;
        end else if (!any_cap && w[MB_CMP] && w[MB_MATCH] && !w[MB_PWM]) begin
            m = w[MB_TOG] ? CH_TOGGLE : CH_TIMER;
        end else if (!any_cap && w[MB_CMP] && w[MB_PWM] && !w[MB_MATCH]) begin
            if (w[MB_TOG])
                m = CH_FREQ;
            else
                m = w[MB_WIDE] ? CH_PWM_WIDE : CH_PWM_NARROW;
        end
        return m;
    endfunction

endpackage

// File: rtl/ccu_insync.sv
module ccu_insync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_sh;
    logic                   synced;
    logic                   hist_q;
    logic                   level_q;
    logic                   steady;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= pin_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_sh <= '0;
                else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign synced = sync_sh[SYNC_STAGES-1];
    assign steady = (synced == hist_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q  <= 1'b0;
            level_q <= 1'b0;
        end else begin
            hist_q <= synced;
            if (steady)
                level_q <= synced;
        end
    end

    assign rise = steady &  synced & ~level_q;
    assign fall = steady & ~synced &  level_q;

endmodule

// File: rtl/ccu_mode_fsm.sv
module ccu_mode_fsm
    import ccu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output chmode_t           mode_q,
    output logic              irq_en,
    output logic              cap_on_rise,
    output logic              cap_on_fall,
    output logic              match_flags
);
    chmode_t mode_d;
    logic    irq_en_d;

    always_comb begin
        mode_d   = mode_q;
        irq_en_d = irq_en;
        if (mode_we) begin
            mode_d   = decode_mode(mode_wdata);
            irq_en_d = mode_wdata[MB_IRQEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= CH_IDLE;
            irq_en <= 1'b0;
        end else begin
            mode_q <= mode_d;
            irq_en <= irq_en_d;
        end
    end

    always_comb begin
        cap_on_rise = 1'b0;
        cap_on_fall = 1'b0;
        match_flags = 1'b0;
        unique case (mode_q)
            CH_CAP_RISE:   cap_on_rise = 1'b1;
            CH_CAP_FALL:   cap_on_fall = 1'b1;
            CH_CAP_ANY: begin
                cap_on_rise = 1'b1;
                cap_on_fall = 1'b1;
            end
            CH_TIMER,
            CH_TOGGLE:     match_flags = 1'b1;
            CH_IDLE,
            CH_FREQ,
            CH_PWM_NARROW,
            CH_PWM_WIDE:   ;
            default:       ;
        endcase
    end

endmodule

// File: rtl/ccu_out_gen.sv
module ccu_out_gen
    import ccu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chmode_t          mode_q,
    input  logic             hit_full,
    input  logic             hit_low,
    input  logic [CNT_W-1:0] count_in,
    input  logic [CNT_W-1:0] ccreg,
    output logic             pin_out
);
    localparam int LO_W = CNT_W / 2;

    logic pin_d;

    always_comb begin
        pin_d = pin_out;
        unique case (mode_q)
            CH_TOGGLE:     if (hit_full) pin_d = ~pin_out;
            CH_FREQ:       if (hit_low)  pin_d = ~pin_out;
            CH_PWM_NARROW: pin_d = !(count_in[LO_W-1:0] < ccreg[LO_W-1:0]);
            CH_PWM_WIDE:   pin_d = !(count_in < ccreg);
            CH_IDLE,
            CH_CAP_RISE,
            CH_CAP_FALL,
            CH_CAP_ANY,
            CH_TIMER:      ;
            default:       ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_out <= 1'b0;
        else        pin_out <= pin_d;
    end

endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_in,
    input  logic             pin_in,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    input  logic             reg_we,
    input  logic [CNT_W-1:0] reg_wdata,
    input  logic             flag_clr,
    output logic             pin_out,
    output logic [CNT_W-1:0] ccreg,
    output logic             flag,
    output logic             irq
);
    localparam int LO_W = CNT_W / 2;

    chmode_t mode_q;
    logic    irq_en, cap_on_rise, cap_on_fall, match_flags;
    logic    rise, fall, capture, hit_full, hit_low, reload, flag_set;
    logic [LO_W-1:0] next_lo;

    ccu_insync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    ccu_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_we     (mode_we),
        .mode_wdata  (mode_wdata),
        .mode_q      (mode_q),
        .irq_en      (irq_en),
        .cap_on_rise (cap_on_rise),
        .cap_on_fall (cap_on_fall),
        .match_flags (match_flags)
    );

    assign hit_full = (count_in == ccreg);
    assign hit_low  = (count_in[LO_W-1:0] == ccreg[LO_W-1:0]);
    assign capture  = (cap_on_rise & rise) | (cap_on_fall & fall);
    assign reload   = (mode_q == CH_FREQ) & hit_low;
    assign next_lo  = ccreg[LO_W-1:0] + ccreg[CNT_W-1:LO_W];
    assign flag_set = capture | (match_flags & hit_full);

    ccu_out_gen #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .hit_full (hit_full),
        .hit_low  (hit_low),
        .count_in (count_in),
        .ccreg    (ccreg),
        .pin_out  (pin_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccreg <= '0;
        end else if (reg_we) begin
            ccreg <= reg_wdata;
        end else if (capture) begin
            ccreg <= count_in;
        end else if (reload) begin
            ccreg[LO_W-1:0] <= next_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;

endmodule

// File: rtl/ccu_channel_chk.sv
module ccu_channel_chk
    import ccu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input chmode_t          mode_q,
    input logic [CNT_W-1:0] count_in,
    input logic [CNT_W-1:0] ccreg,
    input logic             reg_we,
    input logic             flag,
    input logic             flag_clr,
    input logic             irq,
    input logic             pin_out
);
    localparam int LO_W = CNT_W / 2;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag); // R9

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CH_TIMER || mode_q == CH_TOGGLE) && count_in == ccreg |=> flag); // R5

    AST_TOGGLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == CH_TOGGLE && count_in == ccreg |=> pin_out != $past(pin_out)); // R5

    AST_FREQ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == CH_FREQ && count_in[LO_W-1:0] == ccreg[LO_W-1:0] && !reg_we
        |=> ccreg[LO_W-1:0] == $past(ccreg[LO_W-1:0] + ccreg[CNT_W-1:LO_W])); // R8

    AST_PWM_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CH_PWM_NARROW || mode_q == CH_PWM_WIDE) && !reg_we |=> $stable(ccreg)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == CH_IDLE && !reg_we |=> $stable(ccreg) && $stable(pin_out)); // R2

endmodule

bind ccu_channel ccu_channel_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .count_in (count_in),
    .ccreg    (ccreg),
    .reg_we   (reg_we),
    .flag     (flag),
    .flag_clr (flag_clr),
    .irq      (irq),
    .pin_out  (pin_out)
);

// File: tb/ccu_channel_tb.sv
module ccu_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] count_in;
    logic        pin_in, mode_we, reg_we, flag_clr;
    logic [7:0]  mode_wdata;
    logic [15:0] reg_wdata;
    logic        pin_out, flag, irq;
    logic [15:0] ccreg;

    always #10 clk = ~clk; // 50 MHz

    ccu_channel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_in   (count_in),
        .pin_in     (pin_in),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .flag_clr   (flag_clr),
        .pin_out    (pin_out),
        .ccreg      (ccreg),
        .flag       (flag),
        .irq        (irq)
    );

    // mode word values per R2
    localparam logic [7:0] M_RISE_IE = 8'h81;
    localparam logic [7:0] M_FALL    = 8'h02;
    localparam logic [7:0] M_ANY     = 8'h03;
    localparam logic [7:0] M_TIMER   = 8'h0C;
    localparam logic [7:0] M_BAD     = 8'h2C;
    localparam logic [7:0] M_TOGGLE  = 8'h1C;
    localparam logic [7:0] M_PWM8    = 8'h24;
    localparam logic [7:0] M_PWM16   = 8'h64;
    localparam logic [7:0] M_FREQ    = 8'h34;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_cc = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic push_exp(input logic [15:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic set_mode(input logic [7:0] w);
        mode_we = 1'b1; mode_wdata = w;
        step(1);
        mode_we = 1'b0;
    endtask

    task automatic write_reg(input logic [15:0] v, input string tag);
        push_exp(v, tag);
        reg_we = 1'b1; reg_wdata = v;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic pulse_clr;
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    // scoreboard monitor: every change of ccreg must match the next expected item
    always @(negedge clk) begin
        if (rst_n && ccreg !== last_cc) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: unexpected ccreg change got %0h expected %0h", ccreg, last_cc);
            end else begin
                chk(tag_q.pop_front(), ccreg, exp_q.pop_front());
            end
            last_cc = ccreg;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; count_in = '0; pin_in = 1'b0; mode_we = 1'b0; mode_wdata = '0;
        reg_we = 1'b0; reg_wdata = '0; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        chk("R1 ccreg", ccreg, 0);
        chk("R1 flag", flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 pin", pin_out, 0);

        // rising capture with interrupt enabled, exact latency
        set_mode(M_RISE_IE);
        count_in = 16'h1111; pin_in = 1'b1;
        push_exp(16'h1111, "R3 rise capture");
        step(3);
        chk("R3 not before 4th edge", ccreg, 16'h0000);
        step(1);
        chk("R3 at 4th edge", ccreg, 16'h1111);
        chk("R3 flag", flag, 1);
        chk("R10 irq enabled", irq, 1);
        pulse_clr;
        chk("R9 cleared", flag, 0);
        chk("R10 irq follows", irq, 0);
        count_in = 16'h2222; pin_in = 1'b0;
        step(6);
        chk("R4 wrong polarity flag", flag, 0);
        chk("R4 wrong polarity ccreg", ccreg, 16'h1111);

        // falling capture, interrupt disabled
        set_mode(M_FALL);
        count_in = 16'h2A2A; pin_in = 1'b1;
        step(6);
        chk("R4 rise ignored in fall mode", flag, 0);
        count_in = 16'h3333; push_exp(16'h3333, "R3 fall capture"); pin_in = 1'b0;
        step(6);
        chk("R3 fall flag", flag, 1);
        chk("R10 irq masked", irq, 0);
        step(5);
        chk("R9 sticky", flag, 1);
        pulse_clr;

        // either edge
        set_mode(M_ANY);
        count_in = 16'h4444; push_exp(16'h4444, "R3 any rise"); pin_in = 1'b1;
        step(6);
        count_in = 16'h5555; push_exp(16'h5555, "R3 any fall"); pin_in = 1'b0;
        step(6);
        chk("R3 any flag", flag, 1);
        pulse_clr;

        // one-clock glitch
        count_in = 16'h6666; pin_in = 1'b1;
        step(1);
        pin_in = 1'b0;
        step(8);
        chk("R4 glitch ccreg", ccreg, 16'h5555);
        chk("R4 glitch flag", flag, 0);

        // software timer
        set_mode(M_TIMER);
        count_in = 16'h0000;
        write_reg(16'h0040, "R11 write");
        count_in = 16'h003F; step(1);
        chk("R5 no early match", flag, 0);
        count_in = 16'h0040; step(1);
        count_in = 16'h0041;
        chk("R5 timer flag", flag, 1);
        chk("R5 timer pin held", pin_out, 0);
        pulse_clr;
        count_in = 16'h0040; flag_clr = 1'b1; step(1);
        flag_clr = 1'b0; count_in = 16'h0041;
        chk("R9 set wins", flag, 1);
        pulse_clr;
        chk("R9 clear", flag, 0);

        // invalid word -> idle
        set_mode(M_BAD);
        count_in = 16'h0040; step(2);
        count_in = 16'h0041;
        chk("R2 idle no flag", flag, 0);
        chk("R2 idle pin", pin_out, 0);

        // high-speed toggle
        set_mode(M_TOGGLE);
        count_in = 16'h0040; step(1); count_in = 16'h0041;
        chk("R5 toggle high", pin_out, 1);
        chk("R5 toggle flag", flag, 1);
        step(2);
        chk("R5 toggle holds", pin_out, 1);
        count_in = 16'h0040; step(1); count_in = 16'h0041;
        chk("R5 toggle low", pin_out, 0);
        pulse_clr;

        // 8-bit PWM
        count_in = 16'h0011;
        set_mode(M_PWM8);
        write_reg(16'h0080, "R11 write");
        count_in = 16'h007F; step(1);
        chk("R6 below", pin_out, 0);
        count_in = 16'h0080; step(1);
        chk("R6 equal", pin_out, 1);
        count_in = 16'hFF05; step(1);
        chk("R6 low byte only", pin_out, 0);
        count_in = 16'h00FF; step(1);
        chk("R6 above", pin_out, 1);

        // 16-bit PWM
        set_mode(M_PWM16);
        write_reg(16'h8000, "R11 write");
        count_in = 16'h7FFF; step(1);
        chk("R7 below", pin_out, 0);
        count_in = 16'h8000; step(1);
        chk("R7 equal", pin_out, 1);
        count_in = 16'h00FF; step(1);
        chk("R7 full compare", pin_out, 0);

        // frequency output
        set_mode(M_FREQ);
        write_reg(16'h1005, "R11 write");
        count_in = 16'h0005; push_exp(16'h1015, "R8 reload"); step(1);
        count_in = 16'h0006;
        chk("R8 toggle", pin_out, 1);
        step(2);
        chk("R8 hold", pin_out, 1);
        count_in = 16'h0015; push_exp(16'h1025, "R8 reload 2"); step(1);
        count_in = 16'h0006;
        chk("R8 toggle 2", pin_out, 0);
        count_in = 16'h00FF;
        write_reg(16'h20F0, "R11 write");
        count_in = 16'h00F0; push_exp(16'h2010, "R8 wrap"); step(1);
        count_in = 16'h00FF;
        chk("R8 wrap value", ccreg, 16'h2010);
        chk("R8 wrap toggle", pin_out, 1);
        count_in = 16'h0010;
        write_reg(16'h0133, "R11 write beats reload");
        count_in = 16'h00FF;
        chk("R11 priority", ccreg, 16'h0133);

        step(3);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule